// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block sits between two 16-bit buses, an A side and a B side, and moves an 18-bit word in each direction: sixteen data bits and one parity bit per byte. The parity bits are not computed or checked here. They are stored and forwarded with their bytes, so that a neighbouring block can generate or verify them.

Each direction has its own storage element and its own three controls: a latch enable, a clock and an active-low output enable. While the latch enable is high, the element is transparent and the far side follows the near side. While it is low, the element behaves as an edge-triggered register that loads on the rising edge of that direction's clock. When the latch enable falls, the element keeps the last word it passed through until the next clock edge.

The pads are split into separate input, output and drive-enable signals. A disabled side drives zeros, which stand in for high impedance. An asynchronous active-low reset clears both stored words.

Top module: `xcvr_bidir`

## Requirements
- R1: Each path carries an 18-bit word. Data bits 7:0 travel with parity bit 0, and data bits 15:8 travel with parity bit 1. The parity bits arrive at the far side unchanged.
- R2: While a path's latch enable is high, its far-side output follows its near-side input with no clock edge.
- R3: While a path's latch enable is low, a rising edge of that path's clock loads the near-side input. The far side shows the loaded word from that edge on.
- R4: While a path's latch enable is low and no clock edge occurs, near-side input changes have no effect on the far side. When the latch enable falls, the far side keeps the last word passed through in transparent mode.
- R5: While a path's output enable is high, the far-side drive enable is 0 and the far-side data and parity outputs are 0.
- R6: While a path's output enable is low, the far-side drive enable is 1.
- R7: The asynchronous active-low reset clears both stored words to zero. With latch enables low and output enables low, both sides then drive zero.
- R8: The controls of one path have no effect on the stored word or outputs of the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both stored words |
| a_dat_i | input | 16 | Data arriving from the A-side pads |
| a_par_i | input | 2 | Byte parity arriving from the A-side pads |
| a_dat_o | output | 16 | Data driven onto the A-side pads (B-to-A path) |
| a_par_o | output | 2 | Byte parity driven onto the A-side pads |
| a_drv_o | output | 1 | A-side pad drive enable, high when driving |
| b_dat_i | input | 16 | Data arriving from the B-side pads |
| b_par_i | input | 2 | Byte parity arriving from the B-side pads |
| b_dat_o | output | 16 | Data driven onto the B-side pads (A-to-B path) |
| b_par_o | output | 2 | Byte parity driven onto the B-side pads |
| b_drv_o | output | 1 | B-side pad drive enable, high when driving |
| ab_le | input | 1 | A-to-B latch enable, transparent when high |
| ab_clk | input | 1 | A-to-B load clock, rising edge, used while ab_le is low |
| ab_oe_n | input | 1 | A-to-B active-low output enable for the B side |
| ba_le | input | 1 | B-to-A latch enable, transparent when high |
| ba_clk | input | 1 | B-to-A load clock, rising edge, used while ba_le is low |
| ba_oe_n | input | 1 | B-to-A active-low output enable for the A side |

## Verification
The assertions watch each path at every edge of its own clock:
- transparent pass-through of data and parity whenever the path is open and enabled;
- the word loaded at one edge still being presented at the next edge while the latch enable stays low;
- the zeroed, undriven output whenever the output enable is high;
- the drive enable whenever the output enable is low.

Some behaviour happens between clock edges, and only the bench's scenarios can show it:
- the hold after the latch enable falls;
- input changes ignored between edges;
- the reset clearing the stored words;
- one path's controls leaving the other path's word untouched.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    PATH_AB = 1'b0,
    PATH_BA = 1'b1
  } path_e;

  localparam int NUM_PATHS = 2;

  // number of parity lanes for a given data and lane width
  function automatic int lanes_of(input int data_w, input int lane_w);
    return (data_w + lane_w - 1) / lane_w;
  endfunction

  // which parity lane a data bit belongs to
  function automatic int lane_of_bit(input int bit_idx, input int lane_w);
    return bit_idx / lane_w;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
// One path's storage element: transparent latch while le is high,
// rising-edge register while le is low.
module xcvr_store #(
  parameter int WORD_W = 18
) (
  input  logic              rst_n,
  input  logic              le,
  input  logic              clk,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q,
  output logic              loaded_o
);

  logic [WORD_W-1:0] latch_q;
  logic [WORD_W-1:0] reg_q;
  logic              edge_seen;

  // level-sensitive half: tracks d while le is high
  always_latch begin
    if (!rst_n)  latch_q = '0;
    else if (le) latch_q = d;
  end

  // edge-triggered half: loads only while the latch is closed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   reg_q <= '0;
    else if (!le) reg_q <= d;
  end

  // set by a clock edge while closed, cleared when the latch opens
  always_ff @(posedge clk or posedge le or negedge rst_n) begin
    if (!rst_n)  edge_seen <= 1'b0;
    else if (le) edge_seen <= 1'b0;
    else         edge_seen <= 1'b1;
  end

  assign loaded_o = edge_seen;
  assign q = le ? d : (edge_seen ? reg_q : latch_q);

  // R3: a word loaded at one edge is still presented at the next edge
  a_r3_edge_load: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> (le || q == $past(d)))
    else $error("a_r3_edge_load");

endmodule

// File: rtl/xcvr_drive.sv
// Output stage: gates the stored word onto the far-side pads.
module xcvr_drive #(
  parameter int WORD_W = 18
) (
  input  logic              oe_n,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] pad_o,
  output logic              drv_o
);

  assign drv_o = ~oe_n;
  assign pad_o = oe_n ? '0 : word;

endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int PAR_W  = xcvr_pkg::lanes_of(DATA_W, LANE_W),
  localparam int WORD_W = DATA_W + PAR_W
) (
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_dat_i,
  input  logic [PAR_W-1:0]  a_par_i,
  output logic [DATA_W-1:0] a_dat_o,
  output logic [PAR_W-1:0]  a_par_o,
  output logic              a_drv_o,
  input  logic [DATA_W-1:0] b_dat_i,
  input  logic [PAR_W-1:0]  b_par_i,
  output logic [DATA_W-1:0] b_dat_o,
  output logic [PAR_W-1:0]  b_par_o,
  output logic              b_drv_o,
  input  logic              ab_le,
  input  logic              ab_clk,
  input  logic              ab_oe_n,
  input  logic              ba_le,
  input  logic              ba_clk,
  input  logic              ba_oe_n
);
  import xcvr_pkg::*;

  logic [WORD_W-1:0] near_w [NUM_PATHS];
  logic [WORD_W-1:0] held_w [NUM_PATHS];
  logic [WORD_W-1:0] far_w  [NUM_PATHS];
  logic              far_drv [NUM_PATHS];
  logic              loaded  [NUM_PATHS];
  logic              p_le    [NUM_PATHS];
  logic              p_clk   [NUM_PATHS];
  logic              p_oe_n  [NUM_PATHS];

  // parity sits above the data so each lane's bit rides with its byte
  assign near_w[PATH_AB] = {a_par_i, a_dat_i};
  assign near_w[PATH_BA] = {b_par_i, b_dat_i};
  assign p_le[PATH_AB]   = ab_le;
  assign p_le[PATH_BA]   = ba_le;
  assign p_clk[PATH_AB]  = ab_clk;
  assign p_clk[PATH_BA]  = ba_clk;
  assign p_oe_n[PATH_AB] = ab_oe_n;
  assign p_oe_n[PATH_BA] = ba_oe_n;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    xcvr_store #(.WORD_W(WORD_W)) u_store (
      .rst_n    (rst_n),
      .le       (p_le[g]),
      .clk      (p_clk[g]),
      .d        (near_w[g]),
      .q        (held_w[g]),
      .loaded_o (loaded[g])
    );

    xcvr_drive #(.WORD_W(WORD_W)) u_drive (
      .oe_n  (p_oe_n[g]),
      .word  (held_w[g]),
      .pad_o (far_w[g]),
      .drv_o (far_drv[g])
    );

    // R2 and R1: an open, enabled path passes data and parity straight across
    a_r2_pass_through: assert property (@(posedge p_clk[g]) disable iff (!rst_n)
      (p_le[g] && !p_oe_n[g]) |-> (far_w[g] == near_w[g]))
      else $error("a_r2_pass_through");

    // R5: a disabled side is undriven and zero
    a_r5_float: assert property (@(posedge p_clk[g]) disable iff (!rst_n)
      p_oe_n[g] |-> (!far_drv[g] && far_w[g] == '0))
      else $error("a_r5_float");

    // R6: an enabled side is driven
    a_r6_driven: assert property (@(posedge p_clk[g]) disable iff (!rst_n)
      !p_oe_n[g] |-> far_drv[g])
      else $error("a_r6_driven");

    // R4: opening the latch forgets any earlier clocked load
    a_r4_open_clears: assert property (@(posedge p_clk[g]) disable iff (!rst_n)
      p_le[g] |-> !loaded[g])
      else $error("a_r4_open_clears");
  end

  assign b_dat_o = far_w[PATH_AB][DATA_W-1:0];
  assign b_par_o = far_w[PATH_AB][WORD_W-1:DATA_W];
  assign b_drv_o = far_drv[PATH_AB];
  assign a_dat_o = far_w[PATH_BA][DATA_W-1:0];
  assign a_par_o = far_w[PATH_BA][WORD_W-1:DATA_W];
  assign a_drv_o = far_drv[PATH_BA];

endmodule

// File: tb/sim_xcvr_bidir.sv
module sim_xcvr_bidir;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [15:0] a_dat_i, b_dat_i, a_dat_o, b_dat_o;
  logic [1:0]  a_par_i, b_par_i, a_par_o, b_par_o;
  logic        a_drv_o, b_drv_o;
  logic        ab_le, ab_clk, ab_oe_n, ba_le, ba_clk, ba_oe_n;

  xcvr_bidir u0 (
    .rst_n(rst_n),
    .a_dat_i(a_dat_i), .a_par_i(a_par_i),
    .a_dat_o(a_dat_o), .a_par_o(a_par_o), .a_drv_o(a_drv_o),
    .b_dat_i(b_dat_i), .b_par_i(b_par_i),
    .b_dat_o(b_dat_o), .b_par_o(b_par_o), .b_drv_o(b_drv_o),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n)
  );

  typedef struct {
    bit          to_b;   // 1: A-to-B path seen on B side, 0: B-to-A seen on A side
    logic [15:0] dat;
    logic [1:0]  par;
    logic        drv;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // monitor: compares every queued expectation at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [18:0] act, want;
        e = exp_q.pop_front();
        act  = e.to_b ? {b_drv_o, b_par_o, b_dat_o} : {a_drv_o, a_par_o, a_dat_o};
        want = {e.drv, e.par, e.dat};
        n_run++;
        if (act !== want) begin
          n_fail++;
          $display("FAIL %s: actual drv=%b par=%b dat=%h expected drv=%b par=%b dat=%h",
                   e.tag, act[18], act[17:16], act[15:0], want[18], want[17:16], want[15:0]);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic expect_side(input bit to_b, input logic [15:0] d,
                             input logic [1:0] p, input logic drv, input string tag);
    exp_t e;
    e.to_b = to_b; e.dat = d; e.par = p; e.drv = drv; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic pulse_ab();
    step(); ab_clk = 1'b1; #4 ab_clk = 1'b0;
  endtask

  task automatic pulse_ba();
    step(); ba_clk = 1'b1; #4 ba_clk = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    ab_le = 1'b0; ab_clk = 1'b0; ab_oe_n = 1'b0;
    ba_le = 1'b0; ba_clk = 1'b0; ba_oe_n = 1'b0;
    a_dat_i = 16'hFFFF; a_par_i = 2'b11;
    b_dat_i = 16'hC3C3; b_par_i = 2'b10;

    // R7: reset clears both words
    repeat (3) step();
    expect_side(1, 16'h0000, 2'b00, 1'b1, "R7 reset B side");
    expect_side(0, 16'h0000, 2'b00, 1'b1, "R7 reset A side");
    settle();
    step(); rst_n = 1'b1;
    expect_side(1, 16'h0000, 2'b00, 1'b1, "R7 after release B side");
    settle();

    // R5: disable the A-to-B output; R6: B-to-A still driven
    step(); ab_oe_n = 1'b1;
    expect_side(1, 16'h0000, 2'b00, 1'b0, "R5 B side disabled");
    expect_side(0, 16'h0000, 2'b00, 1'b1, "R6 A side driven");
    settle();

    // R2, R1: transparent A-to-B, parity lanes unchanged
    step(); ab_oe_n = 1'b0; ab_le = 1'b1; a_dat_i = 16'h1234; a_par_i = 2'b01;
    expect_side(1, 16'h1234, 2'b01, 1'b1, "R2 transparent AB");
    settle();
    step(); a_dat_i = 16'hBEEF; a_par_i = 2'b10;
    expect_side(1, 16'hBEEF, 2'b10, 1'b1, "R1 parity follows AB");
    expect_side(0, 16'h0000, 2'b00, 1'b1, "R8 BA untouched by AB transparency");
    settle();
    step();
    pulse_ab();   // edge while open: output still follows input
    expect_side(1, 16'hBEEF, 2'b10, 1'b1, "R2 edge while open AB");
    settle();

    // R4: close the latch, then change input
    step(); ab_le = 1'b0;
    expect_side(1, 16'hBEEF, 2'b10, 1'b1, "R4 hold at close AB");
    settle();
    step(); a_dat_i = 16'h5555; a_par_i = 2'b11;
    expect_side(1, 16'hBEEF, 2'b10, 1'b1, "R4 input ignored AB");
    settle();

    // R3: clocked load
    pulse_ab();
    expect_side(1, 16'h5555, 2'b11, 1'b1, "R3 clocked load AB");
    expect_side(0, 16'h0000, 2'b00, 1'b1, "R8 BA untouched by AB clock");
    settle();
    step(); a_dat_i = 16'h0001; a_par_i = 2'b00;
    expect_side(1, 16'h5555, 2'b11, 1'b1, "R4 hold after load AB");
    settle();

    // B-to-A clocked path
    step(); b_dat_i = 16'hA5A5; b_par_i = 2'b11;
    expect_side(0, 16'h0000, 2'b00, 1'b1, "R4 input ignored BA");
    settle();
    pulse_ba();
    expect_side(0, 16'hA5A5, 2'b11, 1'b1, "R3 clocked load BA");
    expect_side(1, 16'h5555, 2'b11, 1'b1, "R8 AB untouched by BA clock");
    settle();

    // B-to-A transparent
    step(); ba_le = 1'b1; b_dat_i = 16'h0F0F; b_par_i = 2'b01;
    expect_side(0, 16'h0F0F, 2'b01, 1'b1, "R2 transparent BA");
    settle();

    // R5 on the A side, then re-enable
    step(); ba_oe_n = 1'b1;
    expect_side(0, 16'h0000, 2'b00, 1'b0, "R5 A side disabled");
    expect_side(1, 16'h5555, 2'b11, 1'b1, "R8 AB untouched by BA enable");
    settle();
    step(); ba_le = 1'b0; b_dat_i = 16'h7777;
    expect_side(0, 16'h0000, 2'b00, 1'b0, "R5 A side still disabled");
    settle();
    step(); ba_oe_n = 1'b0;
    expect_side(0, 16'h0F0F, 2'b01, 1'b1, "R4 BA kept word through disable");
    settle();

    // second AB load, then R7 mid-run reset
    pulse_ab();
    expect_side(1, 16'h0001, 2'b00, 1'b1, "R3 second load AB");
    settle();
    step(); rst_n = 1'b0;
    expect_side(1, 16'h0000, 2'b00, 1'b1, "R7 mid-run reset B side");
    expect_side(0, 16'h0000, 2'b00, 1'b1, "R7 mid-run reset A side");
    settle();
    step(); rst_n = 1'b1;
    settle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule